// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a clause-22 MII management link. A client raises a read or a write strobe together with a 5-bit PHY address, a register address and, for a write, a 16-bit value. The block then produces the management clock (MDC) from the system clock and either drives or releases the shared data line (MDIO) through an output value and an output enable. A read ends with the 16-bit register value on the result bus and a one-cycle done pulse. A write ends with a done pulse alone. A busy flag stays high for the whole frame, and the block ignores any request it receives while a frame is in progress.

Every frame starts with a run of 33 clocked ones. A read header carries two extra leading ones in front of the normal start and opcode fields. After the header, 19 clocks follow with the line released. The 16 bits in the middle of those 19 are kept as the result. A write sends one 32-bit word and then two clocks with the line released. The divider sets the MDC half period in system-clock cycles. Its default comes from the stated system clock so that MDC never runs faster than 2.5 MHz. The request carries a register address that is wider than five bits. Any address above 31 is refused without touching the bus.

Top module: `mdio_master`

## Requirements
- R1: Every accepted frame begins with 33 MDC cycles during which the output enable is 1 and MDIO is 1.
- R2: After the preamble, a read drives 16 bits MSB first: 1, 1, 0, 1, 1, 0, then the PHY address (bit 4 first), then register address bits 4..0.
- R3: After its header, a read releases MDIO (output enable 0) for 19 MDC cycles, 68 cycles in all. The samples taken at rising edges 3 to 18 of those 19 become the result, MSB first. Samples 1, 2 and 19 are discarded.
- R4: After the preamble, a write drives 32 bits MSB first: 0, 1, 0, 1, the PHY address, register address bits 4..0, 1, 0, then the 16 data bits.
- R5: A write ends with 2 MDC cycles with MDIO released, 67 cycles in all. The output enable is 0 whenever no frame runs.
- R6: A request whose register address is above 31 causes no MDC edge and no driven bit. Done pulses in the cycle after the request. For a read the result is 0xFFFF.
- R7: Each MDC phase lasts DIV_HALF system cycles, so a frame holds MDC high for exactly DIV_HALF times its clock count. By default DIV_HALF is the smallest value that keeps MDC at or below MDC_MAX_HZ. MDC is low when idle.
- R8: MDIO and its output enable change only while MDC is low. They never change in the cycle in which MDC rises. Input is sampled in the system cycle in which MDC rises.
- R9: Busy goes high in the cycle after an accepted request and falls together with done. A request that arrives while busy is high, or in the cycle in which done is high, is ignored.
- R10: Done is high for exactly one cycle per request, and never while busy is high.
- R11: If read and write strobes are raised in the same cycle, the block runs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_ADDR_W | Register address; values above 31 are refused |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Value sampled from MDIO |

## Verification
Two events can land on the same cycle. The first is the completion pulse of one frame arriving together with a client strobe for the next frame. The bench raises a read strobe exactly in the done cycle. It then checks that busy stays low and that MDC stays quiet afterwards, which proves the request was dropped rather than queued. The second is a read strobe and a write strobe raised in the same cycle. The bench captures the resulting frame at each MDC rise and compares it with the read layout, the 68-clock length and the returned value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int PRE_LEN   = 33;   // clocked ones ahead of every frame
   localparam int RD_HDR_W  = 16;   // driven read header bits
   localparam int RD_SMP_N  = 19;   // released clocks in a read
   localparam int WR_WORD_W = 32;   // driven write word bits
   localparam int WR_TAIL_N = 2;    // released clocks closing a write
   localparam int DATA_W    = 16;

   localparam int RD_DRV = PRE_LEN + RD_HDR_W;     // 49
   localparam int RD_LEN = RD_DRV + RD_SMP_N;      // 68
   localparam int WR_DRV = PRE_LEN + WR_WORD_W;    // 65
   localparam int WR_LEN = WR_DRV + WR_TAIL_N;     // 67
   localparam int TX_W   = WR_DRV;                 // longest driven run
   localparam int FRM_CW = $clog2(RD_LEN + 1);

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   function automatic logic [RD_HDR_W-1:0] rd_header(input logic [4:0] phy,
                                                      input logic [4:0] ra);
      return {2'b11, 2'b01, 2'b10, phy, ra};
   endfunction

   function automatic logic [WR_WORD_W-1:0] wr_word(input logic [4:0] phy,
                                                    input logic [4:0] ra,
                                                    input logic [DATA_W-1:0] wd);
      return {2'b01, 2'b01, phy, ra, 2'b10, wd};
   endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int DIV_HALF = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   logic wrap;
   logic mdc_q;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("mdio_clkdiv: DIV_HALF must be at least 1");
      end
      if (DIV_HALF == 1) begin : g_nocnt
         assign wrap = run;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DIV_HALF - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign wrap = run && (cnt_q == CW'(DIV_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
      end else if (!run) begin
         mdc_q <= 1'b0;
      end else if (wrap) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc       = mdc_q;
   assign rise_tick = wrap && !mdc_q;
   assign fall_tick = wrap &&  mdc_q;

endmodule

// File: rtl/mdio_txshift.sv
module mdio_txshift #(
   parameter int TX_W = 65
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TX_W-1:0] load_val,
   input  logic            shift,
   output logic            bit_o
);
   logic [TX_W-1:0] sr_q;

   generate
      if (TX_W < 2) begin : g_bad_w
         $error("mdio_txshift: TX_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else if (shift) begin
         sr_q <= {sr_q[TX_W-2:0], 1'b0};
      end
   end

   assign bit_o = sr_q[TX_W-1];

endmodule

// File: rtl/mdio_rxcapture.sv
module mdio_rxcapture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              keep,
   input  logic              din,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] sr_q;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("mdio_rxcapture: DATA_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (clr) begin
         sr_q <= '0;
      end else if (keep) begin
         sr_q <= {sr_q[DATA_W-2:0], din};
      end
   end

   assign data = sr_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int SYS_CLK_HZ = 100_000_000,
   parameter int MDC_MAX_HZ = 2_500_000,
   parameter int DIV_HALF   = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ),
   parameter int REG_ADDR_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_rd,
   input  logic                  req_wr,
   input  logic [4:0]            req_phy,
   input  logic [REG_ADDR_W-1:0] req_reg,
   input  logic [15:0]           req_wdata,
   output logic [15:0]           rsp_rdata,
   output logic                  rsp_done,
   output logic                  busy,
   output logic                  mdc,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   input  logic                  mdio_i
);
   localparam int SMP_CW = $clog2(RD_SMP_N + 1);

   generate
      if (REG_ADDR_W < 5) begin : g_bad_ra
         $error("mdio_master: REG_ADDR_W must be at least 5");
      end
      if (DIV_HALF < 1) begin : g_bad_div
         $error("mdio_master: DIV_HALF must be at least 1");
      end
   endgenerate

   seq_state_t          st_q;
   logic                rd_q;
   logic                done_q;
   logic [DATA_W-1:0]   rdata_q;
   logic [FRM_CW-1:0]   bit_q;

   logic reg_ok;
   logic accept, start_frame, reject;
   logic pick_rd;
   logic rise_tick, fall_tick;
   logic last_bit, drive_now, in_samp, keep_smp;
   logic [FRM_CW-1:0] last_idx, drv_len;
   logic [SMP_CW-1:0] smp_idx;
   logic [TX_W-1:0]   tx_load;
   logic              tx_bit;
   logic [DATA_W-1:0] rx_data;

   // address range check; a plain 5-bit field needs none
   generate
      if (REG_ADDR_W > 5) begin : g_ra_wide
         assign reg_ok = ~|req_reg[REG_ADDR_W-1:5];
      end else begin : g_ra_narrow
         assign reg_ok = 1'b1;
      end
   endgenerate

   assign pick_rd     = req_rd;            // read wins a strobe collision
   assign accept      = (req_rd || req_wr) && (st_q == SEQ_IDLE) && !done_q;
   assign start_frame = accept && reg_ok;
   assign reject      = accept && !reg_ok;

   always_comb begin
      if (pick_rd) begin
         tx_load = {{PRE_LEN{1'b1}}, rd_header(req_phy, req_reg[4:0]),
                    {(TX_W - PRE_LEN - RD_HDR_W){1'b0}}};
      end else begin
         tx_load = {{PRE_LEN{1'b1}}, wr_word(req_phy, req_reg[4:0], req_wdata)};
      end
   end

   assign last_idx  = rd_q ? FRM_CW'(RD_LEN - 1) : FRM_CW'(WR_LEN - 1);
   assign drv_len   = rd_q ? FRM_CW'(RD_DRV)     : FRM_CW'(WR_DRV);
   assign last_bit  = (bit_q == last_idx);
   assign drive_now = (st_q == SEQ_RUN) && (bit_q < drv_len);
   assign in_samp   = rd_q && (bit_q >= FRM_CW'(RD_DRV));
   assign smp_idx   = in_samp ? SMP_CW'(bit_q - FRM_CW'(RD_DRV)) : '0;
   // keep only the samples between turnaround and the idle bit
   assign keep_smp  = rise_tick && in_samp && (st_q == SEQ_RUN) &&
                      (smp_idx >= SMP_CW'(2)) &&
                      (smp_idx <= SMP_CW'(RD_SMP_N - 2));

   mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (st_q == SEQ_RUN),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_txshift #(.TX_W(TX_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_frame),
      .load_val (tx_load),
      .shift    (fall_tick && !last_bit),
      .bit_o    (tx_bit)
   );

   mdio_rxcapture #(.DATA_W(DATA_W)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_frame),
      .keep  (keep_smp),
      .din   (mdio_i),
      .data  (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         rd_q    <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
         bit_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (start_frame) begin
                  st_q  <= SEQ_RUN;
                  rd_q  <= pick_rd;
                  bit_q <= '0;
               end else if (reject) begin
                  done_q <= 1'b1;
                  if (pick_rd) begin
                     rdata_q <= '1;
                  end
               end
            end
            SEQ_RUN: begin
               if (fall_tick) begin
                  if (last_bit) begin
                     st_q   <= SEQ_IDLE;
                     done_q <= 1'b1;
                     if (rd_q) begin
                        rdata_q <= rx_data;
                     end
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == SEQ_RUN);
   assign rsp_done  = done_q;
   assign rsp_rdata = rdata_q;
   assign mdio_oe   = drive_now;
   assign mdio_o    = drive_now ? tx_bit : 1'b0;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req_rd,
   input logic req_wr,
   input logic busy,
   input logic rsp_done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   AST_OUT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8

   AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc); // R7

   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R5

   AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> rsp_done); // R9

   AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_rd || req_wr) && !busy && !rsp_done) |=> (busy || rsp_done)); // R9

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R10

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !busy); // R10

endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_rd   (req_rd),
   .req_wr   (req_wr),
   .busy     (busy),
   .rsp_done (rsp_done),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;      // 10 MHz system clock, 2.5 MHz MDC
   localparam int RD_N       = 68;
   localparam int WR_N       = 67;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_wr = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [6:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_done, busy, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int tests = 0;
   int fails = 0;

   mdio_master #(.SYS_CLK_HZ(10_000_000), .MDC_MAX_HZ(2_500_000)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .busy(busy),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // PHY stand-in: record each rising MDC edge, answer on falling edges
   logic        cap_o  [0:127];
   logic        cap_oe [0:127];
   int          n_rise = 0;
   int          hi_cyc = 0;
   logic [18:0] resp19 = '1;

   always @(posedge mdc) begin
      if (n_rise < 128) begin
         cap_o[n_rise]  = mdio_o;
         cap_oe[n_rise] = mdio_oe;
      end
      n_rise = n_rise + 1;
   end

   always @(negedge mdc) begin
      if (n_rise >= 49 && n_rise < 68) mdio_i = resp19[67 - n_rise];
      else                              mdio_i = 1'b1;
   end

   always @(negedge clk) if (mdc) hi_cyc = hi_cyc + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_capture();
      n_rise = 0;
      hi_cyc = 0;
      mdio_i = 1'b1;
   endtask

   // one frame: drive strobes, optionally poke mid-frame, check all of it
   task automatic run_frame(input logic rd, input logic wr, input logic [4:0] phy,
                            input logic [6:0] rg, input logic [15:0] wd,
                            input logic [15:0] rsp, input bit poke);
      logic [15:0] hdr;
      logic [31:0] word;
      logic [32:0] pre;
      int n_exp, n_drv, oe_bad, waited;
      bit is_rd;
      is_rd = rd;
      clear_capture();
      resp19 = {2'b10, rsp, 1'b1};
      @(negedge clk);
      req_rd = rd; req_wr = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
      chk("R9 busy after accept", busy, 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         req_wr = 1'b1; req_phy = 5'h1F; req_reg = 7'h00; req_wdata = 16'hFFFF;
         @(negedge clk);
         req_wr = 1'b0;
      end
      waited = 0;
      while (!rsp_done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      chk("R10 done seen", rsp_done, 1);
      n_exp = is_rd ? RD_N : WR_N;
      n_drv = is_rd ? 49 : 65;
      chk(is_rd ? "R3 read clock count" : "R5 write clock count", n_rise, n_exp);
      chk("R7 mdc high cycles", hi_cyc, n_exp * HALF);
      for (int i = 0; i < 33; i++) pre[32-i] = cap_o[i];
      chk("R1 preamble", {31'b0, pre == '1}, 1);
      oe_bad = 0;
      for (int i = 0; i < n_exp && i < 128; i++)
         if (cap_oe[i] !== (i < n_drv)) oe_bad++;
      chk(is_rd ? "R3 release pattern" : "R5 release pattern", oe_bad, 0);
      if (is_rd) begin
         for (int i = 0; i < 16; i++) hdr[15-i] = cap_o[33+i];
         chk("R2 read header", hdr, {6'b110110, phy, rg[4:0]});
         chk("R3 read data", rsp_rdata, rsp);
      end else begin
         for (int i = 0; i < 32; i++) word[31-i] = cap_o[33+i];
         chk("R4 write word", word, {4'b0101, phy, rg[4:0], 2'b10, wd});
      end
      @(negedge clk);
      chk("R10 done one cycle", rsp_done, 0);
      if (poke) begin
         repeat (20) @(negedge clk);
         chk("R9 poke ignored no new frame", {busy, mdc}, 0);
      end
   endtask

   // {rd, wr, phy, reg, wdata, response}
   localparam int NV = 6;
   localparam logic [45:0] VEC [NV] = '{
      {1'b1, 1'b0, 5'h01, 7'h01, 16'h0000, 16'h796D},
      {1'b0, 1'b1, 5'h1F, 7'h04, 16'h05E1, 16'h0000},
      {1'b1, 1'b0, 5'h00, 7'h1F, 16'h0000, 16'h8001},
      {1'b0, 1'b1, 5'h15, 7'h00, 16'hA5A5, 16'h0000},
      {1'b1, 1'b0, 5'h0A, 7'h11, 16'h0000, 16'hFFFE},
      {1'b1, 1'b1, 5'h03, 7'h02, 16'h1234, 16'h4321}   // R11 collision
   };

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog run hung");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R5 reset oe", mdio_oe, 0);
      chk("R7 reset mdc", mdc, 0);
      chk("R10 reset done", rsp_done, 0);
      chk("R9 reset busy", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_frame(VEC[v][45], VEC[v][44], VEC[v][43:39], VEC[v][38:32],
                   VEC[v][31:16], VEC[v][15:0], 1'b0);
      end

      // R9: write strobe during a running read is dropped
      run_frame(1'b1, 1'b0, 5'h07, 7'h05, 16'h0, 16'hC3C3, 1'b1);

      // R6: bad address read answers at once with all ones, no bus activity
      clear_capture();
      @(negedge clk);
      req_rd = 1'b1; req_reg = 7'h20; req_phy = 5'h01;
      @(negedge clk);
      req_rd = 1'b0;
      chk("R6 bad read done", rsp_done, 1);
      chk("R6 bad read value", rsp_rdata, 16'hFFFF);
      chk("R6 bad read busy", busy, 0);
      repeat (10) @(negedge clk);
      chk("R6 bad read no mdc", n_rise, 0);

      // R6: bad address write dropped
      clear_capture();
      req_wr = 1'b1; req_reg = 7'h7F; req_wdata = 16'h1111;
      @(negedge clk);
      req_wr = 1'b0;
      chk("R6 bad write done", rsp_done, 1);
      repeat (10) @(negedge clk);
      chk("R6 bad write no mdc", n_rise, 0);
      chk("R6 bad write no drive", mdio_oe, 0);

      // R9: request raised in the done cycle is ignored
      clear_capture();
      req_wr = 1'b1; req_reg = 7'h40; @(negedge clk); req_wr = 1'b0;
      chk("R10 done before overlap", rsp_done, 1);
      req_rd = 1'b1; req_reg = 7'h01;
      @(negedge clk);
      req_rd = 1'b0;
      chk("R9 request in done cycle ignored", {busy, rsp_done}, 0);
      repeat (10) @(negedge clk);
      chk("R9 no frame after done-cycle request", n_rise, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule